// File: doc/BRIEF.md
# Half-Rate DFI Command and Data Sequencer

This block sits on the controller side of a DDR memory path. It turns single read or write requests into command and data signalling for a PHY that runs at twice the system clock. Every system clock carries two command slots, phase 0 and phase 1. The sequencer places a read on phase 0 and a write on phase 1. The other phase carries a no-operation code. It raises the write-data and read-enable strobes at fixed offsets that suit a CAS latency of three. Write data and byte masks for both phases are presented together with the write strobe.

Returned read words from both phases are captured when the PHY's valid strobe arrives. They go back to the requester as one wide response that lasts one cycle. A tracker counts the reads in flight. A return that arrives with nothing outstanding raises a sticky error flag. Writes are held off while a read is still in flight, so write data never competes with returning read data. Refresh, bank and row management, initialization and the PHY itself belong to other blocks.

Top module: `dfi_halfrate_seq`

## Requirements
- R1: A read accepted at a clock edge appears in the next cycle on phase 0, with command bits {cs_n,ras_n,cas_n,we_n} = 0101 and the request's address and bank. In that cycle phase 1 carries 0111 with address and bank zero.
- R2: A write accepted at a clock edge appears in the next cycle on phase 1, with command bits 0100 and the request's address and bank, while phase 0 carries 0111. At most one command is issued per cycle. A cycle with no command drives 0111 and zero address and bank on both phases.
- R3: The read enable is high for exactly the one cycle that follows each read command.
- R4: The write-data enable is high for exactly the one cycle that follows each write command. In that cycle phase 0 carries data bits 63:0 and mask bits 7:0 of the request, and phase 1 carries data bits 127:64 and mask bits 15:8. While the enable is low, data and masks are zero.
- R5: Read data is expected on the return bus three cycles after the read enable, marked by the return valid strobe. Each such strobe retires one outstanding read.
- R6: A return strobe that retires a read produces, in the next cycle, a response valid pulse one cycle long. The response data is {phase-1 word, phase-0 word}.
- R7: Out of reset a read request is always ready. A write request is not ready from the cycle a read is accepted through the cycle its data returns. It becomes ready again in the following cycle.
- R8: A return strobe that arrives when no read is outstanding sets the error flag in the next cycle. The flag then stays set until reset. Such a strobe produces no response.
- R9: While reset is high (synchronous, active high), ready is low and no request is taken. In the cycle after a reset edge, both phases carry NOP and the strobes, the response valid and the error flag are low. Reads that were in flight are forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Column address for the command |
| req_bank | input | 2 | Bank address |
| req_wdata | input | 128 | Write data, low half to phase 0 |
| req_wmask | input | 16 | Byte mask, low half to phase 0 |
| req_ready | output | 1 | Request will be taken at the next edge |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 128 | Read response {phase 1, phase 0} |
| rd_err | output | 1 | Sticky flag for a return with no read outstanding |
| dfi_p0_addr | output | 13 | Phase 0 address |
| dfi_p0_bank | output | 2 | Phase 0 bank |
| dfi_p0_cs_n | output | 1 | Phase 0 chip select, active low |
| dfi_p0_ras_n | output | 1 | Phase 0 row strobe, active low |
| dfi_p0_cas_n | output | 1 | Phase 0 column strobe, active low |
| dfi_p0_we_n | output | 1 | Phase 0 write enable, active low |
| dfi_p1_addr | output | 13 | Phase 1 address |
| dfi_p1_bank | output | 2 | Phase 1 bank |
| dfi_p1_cs_n | output | 1 | Phase 1 chip select, active low |
| dfi_p1_ras_n | output | 1 | Phase 1 row strobe, active low |
| dfi_p1_cas_n | output | 1 | Phase 1 column strobe, active low |
| dfi_p1_we_n | output | 1 | Phase 1 write enable, active low |
| dfi_wrdata_en | output | 1 | Write data enable |
| dfi_wrdata_p0 | output | 64 | Phase 0 write data |
| dfi_wrdata_p1 | output | 64 | Phase 1 write data |
| dfi_wrdata_mask_p0 | output | 8 | Phase 0 byte mask |
| dfi_wrdata_mask_p1 | output | 8 | Phase 1 byte mask |
| dfi_rddata_en | output | 1 | Read data enable |
| dfi_rddata_w0 | input | 64 | Returned phase 0 word |
| dfi_rddata_w1 | input | 64 | Returned phase 1 word |
| dfi_rddata_valid | input | 1 | Return valid strobe |

## Verification
The hardest case to reach is a return strobe at a moment when the tracker holds nothing. A well-behaved PHY never produces one, and a badly timed injection would instead retire a real read. The bench therefore plays the PHY itself. It injects the stray strobe only in a cycle where its own model shows every read already retired, and then checks that the error flag rises and that no response comes out. The write hold-off window is reached by offering a write in every cycle after a read and counting the refused cycles.

// File: rtl/dfi_seq_pkg.sv
package dfi_seq_pkg;

   // Command bits in the order {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      DCMD_RD  = 4'b0101,
      DCMD_WR  = 4'b0100,
      DCMD_NOP = 4'b0111
   } dfi_cmd_e;

   typedef enum logic [1:0] {
      REQ_NONE = 2'd0,
      REQ_RD   = 2'd1,
      REQ_WR   = 2'd2
   } req_kind_e;

endpackage

// File: rtl/dfi_delay_line.sv
module dfi_delay_line #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (W < 1) begin : g_bad_width
         $error("dfi_delay_line: W must be at least 1");
      end
      if (DEPTH < 0) begin : g_bad_depth
         $error("dfi_delay_line: DEPTH must not be negative");
      end

      if (DEPTH == 0) begin : g_wire
         logic unused_clkrst;
         assign unused_clkrst = clk ^ rst;
         assign dout = din;
      end else begin : g_pipe
         logic [W-1:0] stg [DEPTH];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            end else begin
               stg[0] <= din;
               for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
         end
         assign dout = stg[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/dfi_phase_slot.sv
module dfi_phase_slot
   import dfi_seq_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int BANK_W     = 2,
   parameter bit CARRIES_RD = 1'b1,
   parameter bit CARRIES_WR = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  req_kind_e         issue_kind,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic [BANK_W-1:0] issue_bank,
   output dfi_cmd_e          cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BANK_W-1:0] bank_o
);

   logic mine;

   always_comb begin
      mine = (CARRIES_RD && (issue_kind == REQ_RD)) ||
             (CARRIES_WR && (issue_kind == REQ_WR));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_o  <= DCMD_NOP;
         addr_o <= '0;
         bank_o <= '0;
      end else if (mine) begin
         cmd_o  <= (issue_kind == REQ_RD) ? DCMD_RD : DCMD_WR;
         addr_o <= issue_addr;
         bank_o <= issue_bank;
      end else begin
         cmd_o  <= DCMD_NOP;
         addr_o <= '0;
         bank_o <= '0;
      end
   end

endmodule

// File: rtl/dfi_rd_tracker.sv
module dfi_rd_tracker #(
   parameter int PHASE_DW = 64,
   parameter int RET_LAT  = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  rden,
   input  logic                  ret_valid,
   input  logic [PHASE_DW-1:0]   ret_w0,
   input  logic [PHASE_DW-1:0]   ret_w1,
   output logic                  busy,
   output logic                  rsp_valid,
   output logic [2*PHASE_DW-1:0] rsp_data,
   output logic                  err
);

   localparam int CNT_W = $clog2(RET_LAT + 2);

   generate
      if (RET_LAT < 2) begin : g_bad_lat
         $error("dfi_rd_tracker: RET_LAT must be at least 2");
      end
   endgenerate

   logic [RET_LAT-1:0] due_sr;
   logic [CNT_W-1:0]   cnt;
   logic               hit;
   logic               stray;

   always_comb begin
      hit   = ret_valid && (cnt != '0);
      stray = ret_valid && (cnt == '0);
      busy  = (cnt != '0) || (|due_sr);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         due_sr    <= '0;
         cnt       <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         err       <= 1'b0;
      end else begin
         due_sr <= {due_sr[RET_LAT-2:0], rden};
         case ({rden, hit})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         rsp_valid <= hit;
         if (hit) rsp_data <= {ret_w1, ret_w0};
         err <= err | stray;
      end
   end

   AST_RET_ON_TIME: assert property (@(posedge clk) disable iff (rst)
      (ret_valid && (cnt != '0)) |-> due_sr[RET_LAT-1]);               // R5
   AST_RSP_FOLLOWS_RET: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> $past(ret_valid));                                  // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      err |=> err);                                                     // R8
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(err) |-> ($past(ret_valid) && !rsp_valid));                 // R8

endmodule

// File: rtl/dfi_halfrate_seq.sv
module dfi_halfrate_seq
   import dfi_seq_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int BANK_W   = 2,
   parameter int PHASE_DW = 64,
   parameter int CAS_LAT  = 3,
   parameter int RD_PHASE = 0,
   parameter int WR_PHASE = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [BANK_W-1:0]       req_bank,
   input  logic [2*PHASE_DW-1:0]   req_wdata,
   input  logic [2*PHASE_DW/8-1:0] req_wmask,
   output logic                    req_ready,
   output logic                    rsp_valid,
   output logic [2*PHASE_DW-1:0]   rsp_rdata,
   output logic                    rd_err,
   output logic [ADDR_W-1:0]       dfi_p0_addr,
   output logic [BANK_W-1:0]       dfi_p0_bank,
   output logic                    dfi_p0_cs_n,
   output logic                    dfi_p0_ras_n,
   output logic                    dfi_p0_cas_n,
   output logic                    dfi_p0_we_n,
   output logic [ADDR_W-1:0]       dfi_p1_addr,
   output logic [BANK_W-1:0]       dfi_p1_bank,
   output logic                    dfi_p1_cs_n,
   output logic                    dfi_p1_ras_n,
   output logic                    dfi_p1_cas_n,
   output logic                    dfi_p1_we_n,
   output logic                    dfi_wrdata_en,
   output logic [PHASE_DW-1:0]     dfi_wrdata_p0,
   output logic [PHASE_DW-1:0]     dfi_wrdata_p1,
   output logic [PHASE_DW/8-1:0]   dfi_wrdata_mask_p0,
   output logic [PHASE_DW/8-1:0]   dfi_wrdata_mask_p1,
   output logic                    dfi_rddata_en,
   input  logic [PHASE_DW-1:0]     dfi_rddata_w0,
   input  logic [PHASE_DW-1:0]     dfi_rddata_w1,
   input  logic                    dfi_rddata_valid
);

   localparam int NPHASE   = 2;
   localparam int MASK_W   = PHASE_DW / 8;
   localparam int RSP_W    = 2 * PHASE_DW;
   localparam int WBUF_W   = RSP_W + 2 * MASK_W;
   localparam int WR_DLY   = 1;
   localparam int RDEN_DLY = 1;
   localparam int RET_LAT  = CAS_LAT;

   generate
      if (CAS_LAT != 3) begin : g_bad_cl
         $error("dfi_halfrate_seq: only CAS latency 3 is supported");
      end
      if ((RD_PHASE == WR_PHASE) || (RD_PHASE >= NPHASE) || (WR_PHASE >= NPHASE)) begin : g_bad_phase
         $error("dfi_halfrate_seq: read and write phases must be distinct and below 2");
      end
      if ((PHASE_DW % 8) != 0) begin : g_bad_dw
         $error("dfi_halfrate_seq: PHASE_DW must be a multiple of 8");
      end
   endgenerate

   // ---------------- request acceptance ----------------
   req_kind_e         acc_kind;
   logic              rd_busy;
   logic              trk_busy;
   logic              iss_rd_q;
   logic              iss_wr_q;
   logic [WBUF_W-1:0] wbuf_q;

   assign req_ready = !rst && (!req_write || !rd_busy);
   assign rd_busy   = iss_rd_q || dfi_rddata_en || trk_busy;

   always_comb begin
      if (req_valid && req_ready) acc_kind = req_write ? REQ_WR : REQ_RD;
      else                        acc_kind = REQ_NONE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         iss_rd_q <= 1'b0;
         iss_wr_q <= 1'b0;
         wbuf_q   <= '0;
      end else begin
         iss_rd_q <= (acc_kind == REQ_RD);
         iss_wr_q <= (acc_kind == REQ_WR);
         wbuf_q   <= (acc_kind == REQ_WR) ? {req_wmask, req_wdata} : '0;
      end
   end

   // ---------------- command phases ----------------
   dfi_cmd_e          ph_cmd  [NPHASE];
   logic [ADDR_W-1:0] ph_addr [NPHASE];
   logic [BANK_W-1:0] ph_bank [NPHASE];

   generate
      for (genvar p = 0; p < NPHASE; p++) begin : g_phase
         dfi_phase_slot #(
            .ADDR_W     (ADDR_W),
            .BANK_W     (BANK_W),
            .CARRIES_RD (p == RD_PHASE),
            .CARRIES_WR (p == WR_PHASE)
         ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .issue_kind (acc_kind),
            .issue_addr (req_addr),
            .issue_bank (req_bank),
            .cmd_o      (ph_cmd[p]),
            .addr_o     (ph_addr[p]),
            .bank_o     (ph_bank[p])
         );
      end
   endgenerate

   assign {dfi_p0_cs_n, dfi_p0_ras_n, dfi_p0_cas_n, dfi_p0_we_n} = ph_cmd[0];
   assign {dfi_p1_cs_n, dfi_p1_ras_n, dfi_p1_cas_n, dfi_p1_we_n} = ph_cmd[1];
   assign dfi_p0_addr = ph_addr[0];
   assign dfi_p0_bank = ph_bank[0];
   assign dfi_p1_addr = ph_addr[1];
   assign dfi_p1_bank = ph_bank[1];

   // ---------------- write-data strobe ----------------
   logic [WBUF_W:0] wr_dly_out;

   dfi_delay_line #(.W(WBUF_W + 1), .DEPTH(WR_DLY)) u_wr_dly (
      .clk  (clk),
      .rst  (rst),
      .din  ({iss_wr_q, wbuf_q}),
      .dout (wr_dly_out)
   );

   assign dfi_wrdata_en      = wr_dly_out[WBUF_W];
   assign dfi_wrdata_p0      = wr_dly_out[PHASE_DW-1:0];
   assign dfi_wrdata_p1      = wr_dly_out[RSP_W-1:PHASE_DW];
   assign dfi_wrdata_mask_p0 = wr_dly_out[RSP_W+MASK_W-1:RSP_W];
   assign dfi_wrdata_mask_p1 = wr_dly_out[WBUF_W-1:RSP_W+MASK_W];

   // ---------------- read-enable strobe ----------------
   dfi_delay_line #(.W(1), .DEPTH(RDEN_DLY)) u_rden_dly (
      .clk  (clk),
      .rst  (rst),
      .din  (iss_rd_q),
      .dout (dfi_rddata_en)
   );

   // ---------------- read return tracking ----------------
   dfi_rd_tracker #(.PHASE_DW(PHASE_DW), .RET_LAT(RET_LAT)) u_trk (
      .clk       (clk),
      .rst       (rst),
      .rden      (dfi_rddata_en),
      .ret_valid (dfi_rddata_valid),
      .ret_w0    (dfi_rddata_w0),
      .ret_w1    (dfi_rddata_w1),
      .busy      (trk_busy),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_rdata),
      .err       (rd_err)
   );

   // ---------------- assertions ----------------
   AST_RDEN_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
      dfi_rddata_en |-> $past(ph_cmd[RD_PHASE] == DCMD_RD));            // R3
   AST_RD_CMD_THEN_EN: assert property (@(posedge clk) disable iff (rst)
      (ph_cmd[RD_PHASE] == DCMD_RD) |=> dfi_rddata_en);                 // R3
   AST_WREN_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
      dfi_wrdata_en |-> $past(ph_cmd[WR_PHASE] == DCMD_WR));            // R4
   AST_WR_CMD_THEN_EN: assert property (@(posedge clk) disable iff (rst)
      (ph_cmd[WR_PHASE] == DCMD_WR) |=> dfi_wrdata_en);                 // R4
   AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
      $countones({ph_cmd[0] != DCMD_NOP, ph_cmd[1] != DCMD_NOP}) <= 1); // R2
   AST_WR_NOT_OVER_RD: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && req_write) |-> !trk_busy);             // R7
   AST_IDLE_WR_DATA: assert property (@(posedge clk) disable iff (rst)
      !dfi_wrdata_en |-> (dfi_wrdata_p0 == '0 && dfi_wrdata_p1 == '0)); // R4

endmodule

// File: tb/tb_dfi_halfrate_seq.sv
module tb_dfi_halfrate_seq;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_valid = 1'b0;
   logic         req_write = 1'b0;
   logic [12:0]  req_addr = '0;
   logic [1:0]   req_bank = '0;
   logic [127:0] req_wdata = '0;
   logic [15:0]  req_wmask = '0;
   logic         req_ready;
   logic         rsp_valid;
   logic [127:0] rsp_rdata;
   logic         rd_err;
   logic [12:0]  p0_addr, p1_addr;
   logic [1:0]   p0_bank, p1_bank;
   logic         p0_cs, p0_ras, p0_cas, p0_we, p1_cs, p1_ras, p1_cas, p1_we;
   logic         wr_en;
   logic [63:0]  wd_p0, wd_p1;
   logic [7:0]   wm_p0, wm_p1;
   logic         rd_en;
   logic [63:0]  ret_w0 = '0, ret_w1 = '0;
   logic         ret_valid = 1'b0;

   always #5 clk = ~clk;

   dfi_halfrate_seq dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_bank(req_bank), .req_wdata(req_wdata),
      .req_wmask(req_wmask), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rd_err(rd_err),
      .dfi_p0_addr(p0_addr), .dfi_p0_bank(p0_bank), .dfi_p0_cs_n(p0_cs),
      .dfi_p0_ras_n(p0_ras), .dfi_p0_cas_n(p0_cas), .dfi_p0_we_n(p0_we),
      .dfi_p1_addr(p1_addr), .dfi_p1_bank(p1_bank), .dfi_p1_cs_n(p1_cs),
      .dfi_p1_ras_n(p1_ras), .dfi_p1_cas_n(p1_cas), .dfi_p1_we_n(p1_we),
      .dfi_wrdata_en(wr_en), .dfi_wrdata_p0(wd_p0), .dfi_wrdata_p1(wd_p1),
      .dfi_wrdata_mask_p0(wm_p0), .dfi_wrdata_mask_p1(wm_p1),
      .dfi_rddata_en(rd_en), .dfi_rddata_w0(ret_w0), .dfi_rddata_w1(ret_w1),
      .dfi_rddata_valid(ret_valid)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model: per-cycle expectations keyed by cycle number
   int           m_kind [int];   // 1 read, 2 write, in its command cycle
   logic [12:0]  m_addr [int];
   logic [1:0]   m_bank [int];
   logic [143:0] m_wd   [int];   // {mask, data}
   logic [127:0] phy_q  [int];   // data the modelled PHY returns in that cycle
   logic [127:0] rsp_q  [int];   // expected response in that cycle
   int           last_rd_n = -100;
   int           err_from  = 1 << 30;
   int           refused   = 0;

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic chk(bit ok, string req, string what, logic [159:0] act, logic [159:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic compare(int c);
      int k, kp;
      logic [3:0] e0, e1;
      logic [12:0] ea0, ea1;
      logic [1:0] eb0, eb1;
      logic [143:0] ewd;
      bit erv;
      k  = m_kind.exists(c)     ? m_kind[c]     : 0;
      kp = m_kind.exists(c - 1) ? m_kind[c - 1] : 0;
      e0  = (k == 1) ? 4'b0101 : 4'b0111;
      ea0 = (k == 1) ? m_addr[c] : 13'd0;
      eb0 = (k == 1) ? m_bank[c] : 2'd0;
      e1  = (k == 2) ? 4'b0100 : 4'b0111;
      ea1 = (k == 2) ? m_addr[c] : 13'd0;
      eb1 = (k == 2) ? m_bank[c] : 2'd0;
      chk({p0_cs, p0_ras, p0_cas, p0_we, p0_addr, p0_bank} == {e0, ea0, eb0}, "R1",
          "phase0 cmd/addr/bank", {p0_cs, p0_ras, p0_cas, p0_we, p0_addr, p0_bank}, {e0, ea0, eb0});
      chk({p1_cs, p1_ras, p1_cas, p1_we, p1_addr, p1_bank} == {e1, ea1, eb1}, "R2",
          "phase1 cmd/addr/bank", {p1_cs, p1_ras, p1_cas, p1_we, p1_addr, p1_bank}, {e1, ea1, eb1});
      chk(rd_en == (kp == 1), "R3", "read enable", rd_en, (kp == 1));
      ewd = (kp == 2) ? m_wd[c - 1] : '0;
      chk(wr_en == (kp == 2), "R4", "write enable", wr_en, (kp == 2));
      chk({wm_p1, wm_p0, wd_p1, wd_p0} == ewd, "R4", "write data/mask",
          {wm_p1, wm_p0, wd_p1, wd_p0}, ewd);
      erv = rsp_q.exists(c);
      chk(rsp_valid == erv, "R5 R6", "response valid", rsp_valid, erv);
      if (erv) chk(rsp_rdata == rsp_q[c], "R6", "response data", rsp_rdata, rsp_q[c]);
      chk(rd_err == (c >= err_from), "R8", "error flag", rd_err, (c >= err_from));
   endtask

   // one clock: compare, drive the modelled PHY, drive a request, check ready
   task automatic step(bit v, bit w, bit spur, bit r);
      int c, n;
      bit erdy;
      @(negedge clk);
      c = cyc;
      compare(c);
      rst = r;
      if (r) begin
         m_kind.delete(); m_addr.delete(); m_bank.delete(); m_wd.delete();
         phy_q.delete(); rsp_q.delete();
         last_rd_n = -100;
         err_from  = 1 << 30;
         ret_valid = 1'b0;
      end else if (phy_q.exists(c)) begin
         ret_valid = 1'b1;
         {ret_w1, ret_w0} = phy_q[c];
      end else if (spur && (c > last_rd_n + 4)) begin
         ret_valid = 1'b1;
         {ret_w1, ret_w0} = rnd128();
         if (err_from > c + 1) err_from = c + 1;
      end else begin
         ret_valid = 1'b0;
         {ret_w1, ret_w0} = rnd128();
      end
      req_valid = v;
      req_write = w;
      req_addr  = 13'($urandom);
      req_bank  = 2'($urandom);
      req_wdata = rnd128();
      req_wmask = 16'($urandom);
      #1;
      erdy = !r && (!w || (c > last_rd_n + 4));
      chk(req_ready == erdy, r ? "R9" : "R7", "ready", req_ready, erdy);
      if (v && erdy && !r) begin
         n = c + 1;
         if (!w) refused = 0;
         m_kind[n] = w ? 2 : 1;
         m_addr[n] = req_addr;
         m_bank[n] = req_bank;
         if (w) m_wd[n] = {req_wmask, req_wdata};
         else begin
            last_rd_n = n;
            phy_q[n + 4] = rnd128();
            rsp_q[n + 5] = phy_q[n + 4];
         end
      end else if (v && w && !r) begin
         refused++;
      end
   endtask

   task automatic idle(int k);
      for (int i = 0; i < k; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      // reset with a request offered: nothing may be taken (R9)
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1);
      idle(2);
      // single read, single write (R1, R3, R5, R6, R2, R4)
      step(1'b1, 1'b0, 1'b0, 1'b0);
      idle(7);
      step(1'b1, 1'b1, 1'b0, 1'b0);
      idle(3);
      // read then a write offered every cycle: held off for five cycles (R7)
      step(1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
      chk(refused == 5, "R7", "write cycles refused after a read", 160'(refused), 160'd5);
      idle(3);
      // write followed at once by a read
      step(1'b1, 1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      idle(7);
      // back-to-back reads, then back-to-back writes
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
      idle(7);
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
      idle(3);
      // random mix
      for (int i = 0; i < 800; i++) step(($urandom % 3) != 0, $urandom % 2, 1'b0, 1'b0);
      idle(7);
      // stray return strobe with nothing outstanding (R8)
      step(1'b0, 1'b0, 1'b1, 1'b0);
      idle(3);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      idle(8);
      // reset with a read in flight: it is forgotten and the flag clears (R9)
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      idle(8);
      step(1'b1, 1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      idle(8);
      // a second random stretch with stray strobes mixed in
      for (int i = 0; i < 400; i++)
         step(($urandom % 2) != 0, $urandom % 2, ($urandom % 20) == 0, 1'b0);
      idle(8);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule